// File: doc/BRIEF.md
# Bus Byte-Lane and Address-Phase Controller

This block sequences one cycle at a time on a 16-bit bus that carries address and data on the same wires. A requester presents an address, a two-bit lane mask, a refresh flag, a region tag and two per-region address-disable bits. The block accepts the request at a cycle boundary and steps through the T-states T1, T2, T3, any wait states and T4. It drives an active-low high-byte enable and the bit-0 value placed on the multiplexed bus. Together these two signals tell the rest of the system whether the cycle is a word transfer, an upper-byte transfer, a lower-byte transfer or a memory refresh.

The high-byte enable pin also serves as a configuration strap. The block reads it on the first clock edge after reset is released and keeps that value until the next reset. A strap read as high, which is also how an unconnected pin with a pull-up reads, lets the region's disable bit keep the address off the multiplexed bus for lower-memory and upper-memory cycles. The address then appears only on the separate full-width address bus, which saves switching power. A strap read as low keeps the address phase on the multiplexed bus at all times. The block also grants the bus to another master, but only between cycles.

Top module: `bus_lane_ctrl`

## Requirements
- R1: The pair (bheN, adOut[0]) in a non-refresh cycle encodes the lane mask reqLanes, where bit 1 requests the upper byte and bit 0 the lower byte: mask 11 gives (0,0), mask 10 gives (0,1) and mask 01 gives (1,0).
- R2: A cycle requested with reqRefresh=1 drives (bheN, adOut[0]) = (1,1) and raises refreshFlag, whatever the lane mask is. Its address phase is never suppressed.
- R3: tState reports IDLE=0, T1=1, T2=2, T3=3, TW=4, T4=5, HOLD=6. An accepted cycle runs T1, T2, T3, then TW for as long as ready is low at the edge, then T4.
- R4: bheOe is high in every state from T1 to T4, and bheN holds one value from T1 to the end of T4. Outside a cycle bheOe is low.
- R5: While rstN is low and in HOLD, bheOe and adOe are both low and tState is IDLE during reset.
- R6: strapPin is captured on the first rising clock edge after rstN goes high. No request is accepted before or on that edge. Later changes of strapPin have no effect until the next reset.
- R7: When the captured strap is 1 and the region tag is lower (1) with cfgDisLower=1, or upper (2) with cfgDisUpper=1, adOe stays low in T1 and addrSuppressed is high. aBus still carries the full address.
- R8: When the captured strap is 0, or the region tag is other (0), adOe is high in T1 whatever the disable bits say.
- R9: dataPhase is high in T2, T3, TW and T4 whether or not the address phase was suppressed.
- R10: A request with lane mask 00 and reqRefresh=0 is consumed (reqAccept high) with reqError high for that cycle, and no bus cycle starts.
- R11: holdReq is granted only from IDLE or T4, and it takes priority over a pending request. holdAck is high exactly while tState is HOLD. Dropping holdReq returns the block to IDLE.
- R12: A request presented in T4 is accepted there, and T1 of the new cycle follows T4 directly.
- R13: In T1, adOut[15:1] equals address bits 15..1. Throughout T1..T4, aBus equals the full request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| strapPin | input | 1 | Level read back from the shared high-byte-enable pin |
| reqValid | input | 1 | Request present |
| reqAddr | input | 20 | Request address |
| reqLanes | input | 2 | Lane mask, bit 1 upper byte, bit 0 lower byte |
| reqRefresh | input | 1 | Request is a refresh cycle |
| reqRegion | input | 2 | Region tag: 0 other, 1 lower, 2 upper |
| cfgDisLower | input | 1 | Address-disable bit of the lower region |
| cfgDisUpper | input | 1 | Address-disable bit of the upper region |
| ready | input | 1 | Ends wait states when high |
| holdReq | input | 1 | Another master asks for the bus |
| reqAccept | output | 1 | Request consumed this cycle |
| reqError | output | 1 | Consumed request was empty |
| holdAck | output | 1 | Bus granted to the other master |
| tState | output | 3 | Current T-state code |
| bheN | output | 1 | Active-low high-byte enable value |
| bheOe | output | 1 | Output enable of the high-byte enable pin |
| adOut | output | 16 | Multiplexed bus value in the address phase |
| adOe | output | 1 | Multiplexed bus output enable in the address phase |
| addrSuppressed | output | 1 | Address phase held off the multiplexed bus |
| aBus | output | 20 | Separate full-width address bus |
| refreshFlag | output | 1 | Current cycle is a refresh |
| dataPhase | output | 1 | Data phase (T2 to T4) in progress |

## Verification
The bench presents a request on the same edge that captures the strap. A design that counted the strap window wrongly would start a cycle there, or would drive the pin while it is still being read. It flips strapPin after the capture and expects the old suppression decision to stay, which catches a strap that is sampled continuously. It sends refresh cycles into a disabled region under a high strap; a design that suppressed them would hide the (1,1) code from anything that decodes refresh on the multiplexed bus. It also raises holdReq in the middle of a cycle and adds wait states, and it issues back-to-back requests from T4. These tests expose a grant that cuts a cycle short, an enable that drops during a wait, or a dead cycle inserted between requests.

// File: rtl/bus_lane_pkg.sv
package bus_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } busState_e;

  typedef enum logic [1:0] {
    RGN_OTHER = 2'd0,
    RGN_LOWER = 2'd1,
    RGN_UPPER = 2'd2
  } region_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;
    logic sampleStrap;
    logic inCycle;
    logic addrPhase;
    logic dataPhase;
  } laneStrobes_t;

endpackage

// File: rtl/bus_lane_fsm.sv
module bus_lane_fsm
  import bus_lane_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   reqLanes,
  input  logic         reqRefresh,
  input  logic         ready,
  input  logic         holdReq,
  output laneStrobes_t strobes,
  output logic [2:0]   tState,
  output logic         reqAccept,
  output logic         reqError,
  output logic         holdAck
);

  busState_e stateQ, stateD;
  logic      strapDoneQ;
  logic      atBoundary;
  logic      emptyReq;
  logic      startCycle;
  logic      grantHold;

  // strap window: first edge after reset release captures the pin
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strapDoneQ <= 1'b0;
    else       strapDoneQ <= 1'b1;
  end

  assign atBoundary = strapDoneQ && (stateQ == ST_IDLE || stateQ == ST_T4);
  assign grantHold  = atBoundary && holdReq;
  assign emptyReq   = (reqLanes == 2'b00) && !reqRefresh;
  assign reqAccept  = atBoundary && !holdReq && reqValid;
  assign reqError   = reqAccept && emptyReq;
  assign startCycle = reqAccept && !emptyReq;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE, ST_T4: begin
        if (grantHold)       stateD = ST_HOLD;
        else if (startCycle) stateD = ST_T1;
        else                 stateD = ST_IDLE;
      end
      ST_T1:   stateD = ST_T2;
      ST_T2:   stateD = ST_T3;
      ST_T3:   stateD = ready ? ST_T4 : ST_TW;
      ST_TW:   stateD = ready ? ST_T4 : ST_TW;
      ST_HOLD: stateD = holdReq ? ST_HOLD : ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobes.loadReq     = startCycle;
    strobes.sampleStrap = !strapDoneQ;
    strobes.addrPhase   = (stateQ == ST_T1);
    strobes.dataPhase   = (stateQ == ST_T2) || (stateQ == ST_T3) ||
                          (stateQ == ST_TW) || (stateQ == ST_T4);
    strobes.inCycle     = strobes.addrPhase || strobes.dataPhase;
  end

  assign tState  = stateQ;
  assign holdAck = (stateQ == ST_HOLD);

endmodule

// File: rtl/bus_lane_dp.sv
module bus_lane_dp
  import bus_lane_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  laneStrobes_t      strobes,
  input  logic              strapPin,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqLanes,
  input  logic              reqRefresh,
  input  logic [1:0]        reqRegion,
  input  logic              cfgDisLower,
  input  logic              cfgDisUpper,
  output logic              bheN,
  output logic              bheOe,
  output logic [AD_W-1:0]   adOut,
  output logic              adOe,
  output logic              addrSuppressed,
  output logic [ADDR_W-1:0] aBus,
  output logic              refreshFlag
);

  logic [ADDR_W-1:0] addrQ;
  logic [1:0]        lanesQ;
  logic              refreshQ;
  logic              regionDisQ;
  logic              strapQ;
  logic              regionDisD;
  logic              codeBhe;
  logic              codeBit0;
  logic              suppress;

  always_comb begin
    unique case (region_e'(reqRegion))
      RGN_LOWER: regionDisD = cfgDisLower;
      RGN_UPPER: regionDisD = cfgDisUpper;
      default:   regionDisD = 1'b0;
    endcase
  end

  // strap register, held until the next reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    strapQ <= 1'b0;
    else if (strobes.sampleStrap) strapQ <= strapPin;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ      <= '0;
      lanesQ     <= '0;
      refreshQ   <= 1'b0;
      regionDisQ <= 1'b0;
    end else if (strobes.loadReq) begin
      addrQ      <= reqAddr;
      lanesQ     <= reqLanes;
      refreshQ   <= reqRefresh;
      regionDisQ <= regionDisD;
    end
  end

  always_comb begin
    if (refreshQ) begin
      codeBhe  = 1'b1;
      codeBit0 = 1'b1;
    end else begin
      codeBhe  = !lanesQ[1];
      codeBit0 = !lanesQ[0];
    end
  end

  assign suppress       = strapQ && regionDisQ && !refreshQ;
  assign bheOe          = strobes.inCycle;
  assign bheN           = strobes.inCycle ? codeBhe : 1'b1;
  assign adOut          = strobes.addrPhase ? {addrQ[AD_W-1:1], codeBit0} : '0;
  assign adOe           = strobes.addrPhase && !suppress;
  assign addrSuppressed = strobes.addrPhase && suppress;
  assign aBus           = strobes.inCycle ? addrQ : '0;
  assign refreshFlag    = strobes.inCycle && refreshQ;

endmodule

// File: rtl/bus_lane_ctrl.sv
module bus_lane_ctrl
  import bus_lane_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int AD_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapPin,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqLanes,
  input  logic              reqRefresh,
  input  logic [1:0]        reqRegion,
  input  logic              cfgDisLower,
  input  logic              cfgDisUpper,
  input  logic              ready,
  input  logic              holdReq,
  output logic              reqAccept,
  output logic              reqError,
  output logic              holdAck,
  output logic [2:0]        tState,
  output logic              bheN,
  output logic              bheOe,
  output logic [AD_W-1:0]   adOut,
  output logic              adOe,
  output logic              addrSuppressed,
  output logic [ADDR_W-1:0] aBus,
  output logic              refreshFlag,
  output logic              dataPhase
);

  laneStrobes_t strobes;

  bus_lane_fsm i_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqLanes   (reqLanes),
    .reqRefresh (reqRefresh),
    .ready      (ready),
    .holdReq    (holdReq),
    .strobes    (strobes),
    .tState     (tState),
    .reqAccept  (reqAccept),
    .reqError   (reqError),
    .holdAck    (holdAck)
  );

  bus_lane_dp #(.ADDR_W(ADDR_W), .AD_W(AD_W)) i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .strapPin       (strapPin),
    .reqAddr        (reqAddr),
    .reqLanes       (reqLanes),
    .reqRefresh     (reqRefresh),
    .reqRegion      (reqRegion),
    .cfgDisLower    (cfgDisLower),
    .cfgDisUpper    (cfgDisUpper),
    .bheN           (bheN),
    .bheOe          (bheOe),
    .adOut          (adOut),
    .adOe           (adOe),
    .addrSuppressed (addrSuppressed),
    .aBus           (aBus),
    .refreshFlag    (refreshFlag)
  );

  assign dataPhase = strobes.dataPhase;

endmodule

// File: rtl/bus_lane_chk.sv
module bus_lane_chk
  import bus_lane_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [2:0] tState,
  input logic       ready,
  input logic       bheN,
  input logic       bheOe,
  input logic       adBit0,
  input logic       adOe,
  input logic       addrSuppressed,
  input logic       refreshFlag,
  input logic       holdAck,
  input logic       reqError
);

  p_refresh_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    (refreshFlag && tState == ST_T1) |-> (bheN && adBit0 && adOe));

  p_tw_exit_r3: assert property (@(posedge clk) disable iff (!rstN)
    (tState == ST_TW && ready) |=> (tState == ST_T4));

  p_bhe_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tState == ST_T2 || tState == ST_T3 || tState == ST_TW || tState == ST_T4)
      |-> ($stable(bheN) && bheOe));

  p_hold_float_r5: assert property (@(posedge clk) disable iff (!rstN)
    holdAck |-> (!bheOe && !adOe));

  p_suppress_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    addrSuppressed |-> (!adOe && tState == ST_T1));

  p_empty_no_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqError |=> (tState == ST_IDLE));

  p_hold_at_edge_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdAck) |-> ($past(tState) == ST_IDLE || $past(tState) == ST_T4));

endmodule

bind bus_lane_ctrl bus_lane_chk i_chk (
  .clk            (clk),
  .rstN           (rstN),
  .tState         (tState),
  .ready          (ready),
  .bheN           (bheN),
  .bheOe          (bheOe),
  .adBit0         (adOut[0]),
  .adOe           (adOe),
  .addrSuppressed (addrSuppressed),
  .refreshFlag    (refreshFlag),
  .holdAck        (holdAck),
  .reqError       (reqError)
);

// File: tb/test_bus_lane_ctrl.sv
`timescale 1ns/1ps
module test_bus_lane_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapPin = 1'b0;
  logic        reqValid = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [1:0]  reqLanes = '0;
  logic        reqRefresh = 1'b0;
  logic [1:0]  reqRegion = '0;
  logic        cfgDisLower = 1'b0;
  logic        cfgDisUpper = 1'b0;
  logic        ready = 1'b1;
  logic        holdReq = 1'b0;
  logic        reqAccept, reqError, holdAck;
  logic [2:0]  tState;
  logic        bheN, bheOe, adOe, addrSuppressed, refreshFlag, dataPhase;
  logic [15:0] adOut;
  logic [19:0] aBus;

  int vecCount = 0;
  int missCount = 0;

  always #2 clk = ~clk;

  bus_lane_ctrl i_bus_lane_ctrl (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reset, strap capture window, and strap change after capture
  task automatic doReset(logic strap);
    @(negedge clk);
    rstN = 1'b0;
    strapPin = strap;
    reqValid = 1'b0;
    holdReq = 1'b0;
    ready = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R5 reset bheOe", bheOe, 0);
    chk("R5 reset adOe", adOe, 0);
    chk("R5 reset tState", tState, 0);
    @(negedge clk);
    rstN = 1'b1;
    reqValid = 1'b1;
    reqLanes = 2'b11;
    #1;
    chk("R6 no accept before strap edge", reqAccept, 0);
    @(negedge clk);
    #1;
    chk("R6 no cycle on strap edge", tState, 0);
    chk("R6 accept after strap edge", reqAccept, 1);
    reqValid = 1'b0;
    strapPin = ~strap;
  endtask

  task automatic runCycle(string tag, logic [19:0] addr, logic [1:0] lanes,
                          logic refr, logic [1:0] rgn, logic dLo, logic dUp,
                          int waits, logic expBhe, logic expBit0, logic expSupp);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqLanes = lanes; reqRefresh = refr;
    reqRegion = rgn; cfgDisLower = dLo; cfgDisUpper = dUp;
    #1;
    chk({tag, " R3 accept"}, reqAccept, 1);
    @(negedge clk);
    reqValid = 1'b0;
    ready = (waits == 0);
    #1;
    chk({tag, " R3 T1"}, tState, 1);
    chk({tag, " R4 bheOe T1"}, bheOe, 1);
    chk({tag, " R1 bheN"}, bheN, expBhe);
    chk({tag, " R1 bit0"}, adOut[0], expBit0);
    chk({tag, " R7 adOe"}, adOe, !expSupp);
    chk({tag, " R7 suppressed"}, addrSuppressed, expSupp);
    chk({tag, " R13 adOut high"}, adOut[15:1], addr[15:1]);
    chk({tag, " R13 aBus"}, aBus, addr);
    chk({tag, " R2 refreshFlag"}, refreshFlag, refr);
    @(negedge clk); #1;
    chk({tag, " R3 T2"}, tState, 2);
    chk({tag, " R9 dataPhase"}, dataPhase, 1);
    @(negedge clk); #1;
    chk({tag, " R3 T3"}, tState, 3);
    for (int i = 0; i < waits; i++) begin
      @(negedge clk); #1;
      chk({tag, " R3 TW"}, tState, 4);
      chk({tag, " R4 bheN in TW"}, bheN, expBhe);
      chk({tag, " R4 bheOe in TW"}, bheOe, 1);
      if (i == waits - 1) ready = 1'b1;
    end
    @(negedge clk); #1;
    chk({tag, " R3 T4"}, tState, 5);
    chk({tag, " R4 bheN in T4"}, bheN, expBhe);
    chk({tag, " R13 aBus T4"}, aBus, addr);
    @(negedge clk); #1;
    chk({tag, " R4 idle"}, tState, 0);
    chk({tag, " R4 bheOe idle"}, bheOe, 0);
  endtask

  task automatic emptyRequest();
    @(negedge clk);
    reqValid = 1'b1; reqLanes = 2'b00; reqRefresh = 1'b0;
    #1;
    chk("R10 accept empty", reqAccept, 1);
    chk("R10 error pulse", reqError, 1);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chk("R10 no cycle", tState, 0);
    chk("R10 error gone", reqError, 0);
    chk("R10 pin quiet", bheOe, 0);
  endtask

  task automatic holdMidCycle();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 20'h0_1234; reqLanes = 2'b11; reqRefresh = 1'b0;
    reqRegion = 2'd0;
    @(negedge clk);
    reqValid = 1'b0;
    holdReq = 1'b1;
    #1;
    chk("R11 T1 despite hold", tState, 1);
    @(negedge clk); #1;
    chk("R11 no grant in T2", holdAck, 0);
    @(negedge clk); #1;
    chk("R11 no grant in T3", holdAck, 0);
    @(negedge clk);
    reqValid = 1'b1;
    #1;
    chk("R11 T4 reached", tState, 5);
    chk("R11 hold beats request", reqAccept, 0);
    @(negedge clk); #1;
    chk("R11 HOLD state", tState, 6);
    chk("R11 holdAck", holdAck, 1);
    chk("R5 bheOe in hold", bheOe, 0);
    chk("R5 adOe in hold", adOe, 0);
    reqValid = 1'b0;
    holdReq = 1'b0;
    @(negedge clk); #1;
    chk("R11 release to idle", tState, 0);
    chk("R11 holdAck low", holdAck, 0);
  endtask

  task automatic backToBack();
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 20'h3_0F00; reqLanes = 2'b11; reqRefresh = 1'b0;
    reqRegion = 2'd0;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    reqValid = 1'b1; reqAddr = 20'h3_0F02; reqLanes = 2'b01;
    #1;
    chk("R12 in T4", tState, 5);
    chk("R12 accept in T4", reqAccept, 1);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    chk("R12 direct T1", tState, 1);
    chk("R12 new code bheN", bheN, 1);
    chk("R12 new address", aBus, 20'h3_0F02);
    repeat (4) @(negedge clk);
    #1;
    chk("R12 idle after", tState, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    missCount++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    // strap low: address phase always on the bus
    doReset(1'b0);
    runCycle("word", 20'hA_5A5A, 2'b11, 1'b0, 2'd1, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    runCycle("upper", 20'h1_2345, 2'b10, 1'b0, 2'd2, 1'b1, 1'b1, 0, 1'b0, 1'b1, 1'b0);
    runCycle("lower", 20'hF_FFFE, 2'b01, 1'b0, 2'd0, 1'b0, 1'b0, 1, 1'b1, 1'b0, 1'b0);
    runCycle("refresh", 20'h0_0040, 2'b00, 1'b1, 2'd0, 1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b0);
    runCycle("R8 strap0 waits", 20'h5_8000, 2'b11, 1'b0, 2'd1, 1'b1, 1'b0, 3, 1'b0, 1'b0, 1'b0);
    emptyRequest();
    holdMidCycle();
    backToBack();
    // strap high: per-region disable bits apply; pin flipped low after capture
    doReset(1'b1);
    runCycle("R7 lower dis", 20'h0_2468, 2'b11, 1'b0, 2'd1, 1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b1);
    runCycle("R8 upper en", 20'hF_0010, 2'b10, 1'b0, 2'd2, 1'b1, 1'b0, 0, 1'b0, 1'b1, 1'b0);
    runCycle("R7 upper dis", 20'hF_0012, 2'b01, 1'b0, 2'd2, 1'b0, 1'b1, 2, 1'b1, 1'b0, 1'b1);
    runCycle("R8 other region", 20'h7_7776, 2'b11, 1'b0, 2'd0, 1'b1, 1'b1, 0, 1'b0, 1'b0, 1'b0);
    runCycle("R2 refresh lower dis", 20'h0_0080, 2'b11, 1'b1, 2'd1, 1'b1, 1'b1, 0, 1'b1, 1'b1, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule